// File: doc/BRIEF.md
# Commit-Path Runtime Checker

This block sits between the completion side of an out-of-order core and its commit point. Instructions reach it in program order, one per cycle at most, each carrying its PC, its branch outcome, the two source operand values it actually consumed, and the result it wants to write. The block takes two cycles to decide on each instruction. In the first it compares the consumed operand values against a private copy of the architectural register file. In the second it compares the instruction's PC against the successor PC expected from the last committed instruction. Results are trusted and never recomputed: only the inputs an instruction used and its place in the control flow are verified.

An instruction that passes both checks commits, updates the private register copy and moves the expected PC forward. A failing instruction is not committed. The block raises a one-cycle flush request with a fault cause and a refetch PC, drops everything behind it, and enters a degraded mode. In degraded mode the block admits only the single instruction at the refetch PC. Every other arrival is discarded until that instruction commits cleanly, and normal streaming then resumes. When nothing goes wrong the block never stalls and adds no cycles per instruction.

Top module: `commit_path_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cm_valid`, `sq_flush` and `degraded` are 0 and `sq_cause` is 0. The private registers reset to 0 and the expected PC resets to `RESET_PC`.
- R2: An accepted instruction presented in cycle t reaches the commit decision in cycle t+2. Back-to-back instructions are accepted every cycle, and there is no stall input or output.
- R3: If the instruction being decided has a PC different from the expected PC and the last committed instruction was not a branch, the block flushes with `sq_cause` = 2 (bad sequential PC).
- R4: If the instruction being decided has a PC different from the expected PC and the last committed instruction was a branch, the block flushes with `sq_cause` = 1 (bad branch resolution). The expected successor of a taken branch is its target. For any other instruction it is PC + `INSN_BYTES`.
- R5: If the operand A value differs from the private copy of register `in_src_a_idx` as of the decision cycle, the block flushes with `sq_cause` = 3.
- R6: If the operand B value differs from the private copy of register `in_src_b_idx`, the block flushes with `sq_cause` = 4.
- R7: Fault causes are ranked: a control fault wins over an operand A fault, which wins over an operand B fault. `sq_cause` is 0 whenever `sq_flush` is 0.
- R8: On a fault, `cm_valid` stays 0 and `sq_flush` is 1 for that cycle only. `sq_refetch_pc` equals the expected PC. The instruction behind the faulting one and any input arriving in the flush cycle are discarded.
- R9: `degraded` rises in the cycle after a fault. While it is high, an arrival is accepted only if its PC equals the refetch PC and no such instruction is already in flight. All other arrivals are dropped without effect.
- R10: `degraded` falls in the cycle after the re-executed instruction commits. A repeated fault keeps it high and starts a new retry.
- R11: The private register copy changes only when an instruction commits with `cm_dst_we` = 1. An instruction directly behind a committing producer is checked against the newly committed value.
- R12: Invalid slots are not checked, produce no commit, and leave the expected PC and the branch history unchanged.
- R13: On commit, `cm_pc`, `cm_dst_we`, `cm_dst_idx` and `cm_dst_val` carry the committed instruction's PC and write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | instruction present this cycle |
| in_pc | input | PC_W | instruction PC |
| in_is_branch | input | 1 | instruction is a branch |
| in_taken | input | 1 | resolved branch direction |
| in_target | input | PC_W | resolved branch target |
| in_src_a_idx | input | IDX_W | operand A register number |
| in_src_a_val | input | DATA_W | operand A value consumed |
| in_src_b_idx | input | IDX_W | operand B register number |
| in_src_b_val | input | DATA_W | operand B value consumed |
| in_dst_we | input | 1 | instruction writes a register |
| in_dst_idx | input | IDX_W | destination register number |
| in_dst_val | input | DATA_W | result value |
| cm_valid | output | 1 | instruction commits this cycle |
| cm_pc | output | PC_W | PC of committing instruction |
| cm_dst_we | output | 1 | commit writes a register |
| cm_dst_idx | output | IDX_W | committed destination |
| cm_dst_val | output | DATA_W | committed result |
| sq_flush | output | 1 | flush all in-flight work |
| sq_refetch_pc | output | PC_W | PC to restart from (valid with flush) |
| sq_cause | output | 3 | fault code, 0 when no fault |
| degraded | output | 1 | single-instruction retry mode |

## Verification
The hardest situation to reach is a degraded-mode retry surrounded by stray traffic. This means arrivals at the wrong PC and repeat copies of the retry PC while the retry is in flight, sometimes with the retry itself faulting again. The stimulus acts as a small core: it tracks issue-time register values and the PC, and injects operand and PC corruptions in rotation. After a flush it replays from the refetch PC, mixing in stray arrivals that must be dropped. Branch-resolution faults need a corrupted PC directly after a branch, so branches are issued often enough for the PC-skew injections to land on them.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_BRANCH = 3'd1,
    FLT_SEQ    = 3'd2,
    FLT_SRCA   = 3'd3,
    FLT_SRCB   = 3'd4
  } flt_cause_e;

  // Ranked fault selection: control, then operand A, then operand B.
  function automatic flt_cause_e rank_fault(input logic flow_bad,
                                            input logic after_branch,
                                            input logic a_bad,
                                            input logic b_bad);
    if (flow_bad) return after_branch ? FLT_BRANCH : FLT_SEQ;
    if (a_bad)    return FLT_SRCA;
    if (b_bad)    return FLT_SRCB;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/ckr_pipe_reg.sv
module ckr_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill,
  input  logic         load_valid,
  input  logic [W-1:0] load_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= load_valid && !kill;
      q_data  <= load_data;
    end
  end

endmodule

// File: rtl/ckr_shadow_rf.sv
module ckr_shadow_rf #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_idx == IDX_W'(i)) regs_q[i] <= wr_data;
    end
  end

  // A value committing this cycle is seen by the reader right behind it.
  function automatic logic [DATA_W-1:0] fwd_read(input logic [IDX_W-1:0] idx);
    if (wr_en && (wr_idx == idx)) return wr_data;
    return regs_q[idx];
  endfunction

  assign rd_a_data = fwd_read(rd_a_idx);
  assign rd_b_data = fwd_read(rd_b_idx);

  assert_commit_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ckr_flow_check.sv
module ckr_flow_check #(
  parameter int             PC_W       = 16,
  parameter int             INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_valid,
  input  logic [PC_W-1:0] chk_pc,
  input  logic            cm_fire,
  input  logic [PC_W-1:0] cm_pc,
  input  logic            cm_is_branch,
  input  logic            cm_taken,
  input  logic [PC_W-1:0] cm_target,
  output logic            flow_bad,
  output logic            after_branch,
  output logic [PC_W-1:0] exp_pc
);

  logic [PC_W-1:0] exp_q;
  logic            br_q;

  function automatic logic [PC_W-1:0] successor(input logic [PC_W-1:0] pc,
                                                input logic br,
                                                input logic tk,
                                                input logic [PC_W-1:0] tgt);
    return (br && tk) ? tgt : pc + PC_W'(INSN_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= RESET_PC;
      br_q  <= 1'b0;
    end else if (cm_fire) begin
      exp_q <= successor(cm_pc, cm_is_branch, cm_taken, cm_target);
      br_q  <= cm_is_branch;
    end
  end

  assign flow_bad     = chk_valid && (chk_pc != exp_q);
  assign after_branch = br_q;
  assign exp_pc       = exp_q;

  assert_bubble_keeps_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_fire |=> $stable(exp_q) && $stable(br_q));

  assert_commit_matches_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_fire |-> cm_pc == exp_q);

endmodule

// File: rtl/ckr_recovery.sv
module ckr_recovery #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  logic            fault,
  input  logic [PC_W-1:0] fault_pc,
  input  logic            cm_fire,
  output logic            accept,
  output logic            degraded
);

  logic            deg_q;
  logic            busy_q;
  logic [PC_W-1:0] retry_q;
  logic            retry_match;

  assign retry_match = !busy_q && (in_pc == retry_q);
  assign accept      = in_valid && !fault && (!deg_q || retry_match);
  assign degraded    = deg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg_q   <= 1'b0;
      busy_q  <= 1'b0;
      retry_q <= '0;
    end else if (fault) begin
      deg_q   <= 1'b1;
      busy_q  <= 1'b0;
      retry_q <= fault_pc;
    end else if (cm_fire && deg_q) begin
      deg_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (accept && deg_q) begin
      busy_q <= 1'b1;
    end
  end

  assert_fault_enters_degraded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> deg_q && (retry_q == $past(fault_pc)));

  assert_clean_retry_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deg_q && cm_fire && !fault |=> !deg_q);

endmodule

// File: rtl/commit_path_checker.sv
module commit_path_checker
  import ckr_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter int              DATA_W     = 16,
  parameter int              NUM_REGS   = 8,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter int              IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_is_branch,
  input  logic              in_taken,
  input  logic [PC_W-1:0]   in_target,
  input  logic [IDX_W-1:0]  in_src_a_idx,
  input  logic [DATA_W-1:0] in_src_a_val,
  input  logic [IDX_W-1:0]  in_src_b_idx,
  input  logic [DATA_W-1:0] in_src_b_val,
  input  logic              in_dst_we,
  input  logic [IDX_W-1:0]  in_dst_idx,
  input  logic [DATA_W-1:0] in_dst_val,
  output logic              cm_valid,
  output logic [PC_W-1:0]   cm_pc,
  output logic              cm_dst_we,
  output logic [IDX_W-1:0]  cm_dst_idx,
  output logic [DATA_W-1:0] cm_dst_val,
  output logic              sq_flush,
  output logic [PC_W-1:0]   sq_refetch_pc,
  output logic [2:0]        sq_cause,
  output logic              degraded
);

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic              is_br;
    logic              taken;
    logic [PC_W-1:0]   target;
    logic [IDX_W-1:0]  a_idx;
    logic [DATA_W-1:0] a_val;
    logic [IDX_W-1:0]  b_idx;
    logic [DATA_W-1:0] b_val;
    logic              dst_we;
    logic [IDX_W-1:0]  dst_idx;
    logic [DATA_W-1:0] dst_val;
  } slot_t;

  typedef struct packed {
    slot_t op;
    logic  a_bad;
    logic  b_bad;
  } chk_t;

  localparam int SLOT_W = $bits(slot_t);
  localparam int CHK_W  = $bits(chk_t);

  slot_t             in_slot, s1;
  chk_t              s1_chk, s2;
  logic              s1_valid, s2_valid;
  logic              accept, fault, commit_fire;
  logic              flow_bad, after_branch;
  logic              a_bad1, b_bad1;
  logic [DATA_W-1:0] shadow_a, shadow_b;
  logic [PC_W-1:0]   exp_pc;
  flt_cause_e        cause;

  assign in_slot = '{pc: in_pc, is_br: in_is_branch, taken: in_taken, target: in_target,
                     a_idx: in_src_a_idx, a_val: in_src_a_val,
                     b_idx: in_src_b_idx, b_val: in_src_b_val,
                     dst_we: in_dst_we, dst_idx: in_dst_idx, dst_val: in_dst_val};

  // CK1: operand comparison against the private register copy
  ckr_pipe_reg #(.W(SLOT_W)) u_ck1 (
    .clk(clk), .rst_n(rst_n), .kill(fault),
    .load_valid(accept), .load_data(in_slot),
    .q_valid(s1_valid), .q_data(s1)
  );

  ckr_shadow_rf #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit_fire && s2.op.dst_we), .wr_idx(s2.op.dst_idx), .wr_data(s2.op.dst_val),
    .rd_a_idx(s1.a_idx), .rd_b_idx(s1.b_idx),
    .rd_a_data(shadow_a), .rd_b_data(shadow_b)
  );

  assign a_bad1 = s1.a_val != shadow_a;
  assign b_bad1 = s1.b_val != shadow_b;
  assign s1_chk = '{op: s1, a_bad: a_bad1, b_bad: b_bad1};

  // CK2: control-flow check and final verdict
  ckr_pipe_reg #(.W(CHK_W)) u_ck2 (
    .clk(clk), .rst_n(rst_n), .kill(fault),
    .load_valid(s1_valid), .load_data(s1_chk),
    .q_valid(s2_valid), .q_data(s2)
  );

  ckr_flow_check #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC)) u_flow (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(s2_valid), .chk_pc(s2.op.pc),
    .cm_fire(commit_fire), .cm_pc(s2.op.pc), .cm_is_branch(s2.op.is_br),
    .cm_taken(s2.op.taken), .cm_target(s2.op.target),
    .flow_bad(flow_bad), .after_branch(after_branch), .exp_pc(exp_pc)
  );

  assign fault       = s2_valid && (flow_bad || s2.a_bad || s2.b_bad);
  assign commit_fire = s2_valid && !fault;
  assign cause       = s2_valid ? rank_fault(flow_bad, after_branch, s2.a_bad, s2.b_bad)
                                : FLT_NONE;

  ckr_recovery #(.PC_W(PC_W)) u_recovery (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_pc(in_pc),
    .fault(fault), .fault_pc(exp_pc), .cm_fire(commit_fire),
    .accept(accept), .degraded(degraded)
  );

  assign cm_valid      = commit_fire;
  assign cm_pc         = s2.op.pc;
  assign cm_dst_we     = s2.op.dst_we;
  assign cm_dst_idx    = s2.op.dst_idx;
  assign cm_dst_val    = s2.op.dst_val;
  assign sq_flush      = fault;
  assign sq_refetch_pc = exp_pc;
  assign sq_cause      = cause;

  assert_no_commit_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && sq_flush));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_flush |=> !s1_valid && !s2_valid && !sq_flush);

  assert_single_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |-> !(s1_valid && s2_valid));

  assert_cause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_flush == (sq_cause != 3'd0));

  assert_two_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> $past(s1_valid));

endmodule

// File: tb/test_commit_path_checker.sv
module test_commit_path_checker;
  localparam int PC_W = 16, DATA_W = 16, NUM_REGS = 8, IDX_W = 3, STEP = 4;
  localparam int PCM = (1 << PC_W) - 1;
  localparam int DM  = (1 << DATA_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              in_valid, in_is_branch, in_taken, in_dst_we;
  logic [PC_W-1:0]   in_pc, in_target;
  logic [IDX_W-1:0]  in_src_a_idx, in_src_b_idx, in_dst_idx;
  logic [DATA_W-1:0] in_src_a_val, in_src_b_val, in_dst_val;
  logic              cm_valid, cm_dst_we, sq_flush, degraded;
  logic [PC_W-1:0]   cm_pc, sq_refetch_pc;
  logic [IDX_W-1:0]  cm_dst_idx;
  logic [DATA_W-1:0] cm_dst_val;
  logic [2:0]        sq_cause;

  commit_path_checker #(.PC_W(PC_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                        .INSN_BYTES(STEP)) i_commit_path_checker (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_pc(in_pc), .in_is_branch(in_is_branch), .in_taken(in_taken),
    .in_target(in_target), .in_src_a_idx(in_src_a_idx), .in_src_a_val(in_src_a_val),
    .in_src_b_idx(in_src_b_idx), .in_src_b_val(in_src_b_val), .in_dst_we(in_dst_we),
    .in_dst_idx(in_dst_idx), .in_dst_val(in_dst_val),
    .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_dst_we(cm_dst_we), .cm_dst_idx(cm_dst_idx),
    .cm_dst_val(cm_dst_val), .sq_flush(sq_flush), .sq_refetch_pc(sq_refetch_pc),
    .sq_cause(sq_cause), .degraded(degraded)
  );

  typedef struct {
    bit v; int pc; bit br; bit tk; int tgt;
    int ai; int av; int bi; int bv; bit we; int di; int dv;
  } ins_t;

  int total = 0, bad = 0;
  bit done = 0;
  int m_rf[NUM_REGS];
  int m_exp = 0, m_retry = 0;
  bit m_prevbr = 0, m_deg = 0, m_busy = 0;
  ins_t m1, m2;
  int g_rf[NUM_REGS];
  int g_pc = 0;
  int inj_kind = 0;
  int seen[5];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic int succ(input ins_t s);
    return (s.br && s.tk) ? s.tgt : ((s.pc + STEP) & PCM);
  endfunction

  task automatic drive(input ins_t s);
    in_valid = s.v; in_pc = PC_W'(s.pc); in_is_branch = s.br; in_taken = s.tk;
    in_target = PC_W'(s.tgt); in_src_a_idx = IDX_W'(s.ai); in_src_a_val = DATA_W'(s.av);
    in_src_b_idx = IDX_W'(s.bi); in_src_b_val = DATA_W'(s.bv); in_dst_we = s.we;
    in_dst_idx = IDX_W'(s.di); in_dst_val = DATA_W'(s.dv);
  endtask

  task automatic gen_normal(output ins_t s, input bit inject);
    s = '{default: 0};
    s.v = 1; s.pc = g_pc;
    s.br = ($urandom % 10) < 3; s.tk = $urandom % 2;
    s.tgt = (($urandom % 1024) * STEP) & PCM;
    s.ai = $urandom % NUM_REGS; s.bi = $urandom % NUM_REGS;
    s.av = g_rf[s.ai]; s.bv = g_rf[s.bi];
    s.we = !s.br && ($urandom % 4 != 0);
    s.di = $urandom % NUM_REGS; s.dv = $urandom & DM;
    if (inject) begin
      case (inj_kind % 5)
        0: s.av = (s.av ^ (1 + $urandom % 7)) & DM;
        1: s.bv = (s.bv ^ (1 + $urandom % 7)) & DM;
        2: begin s.av = (s.av ^ 3) & DM; s.bv = (s.bv ^ 5) & DM; end
        3: s.pc = (g_pc + STEP) & PCM;
        default: begin s.pc = (g_pc + 2 * STEP) & PCM; s.av = (s.av ^ 1) & DM; end
      endcase
      inj_kind++;
    end
  endtask

  task automatic junk(output ins_t s, input int pc);
    s = '{default: 0};
    s.v = 1; s.pc = pc & PCM; s.we = 1; s.di = $urandom % NUM_REGS; s.dv = $urandom & DM;
    s.av = $urandom & DM; s.bv = $urandom & DM;
  endtask

  task automatic step();
    bit fl, cm, acc;
    int cause;
    ins_t s;
    fl = 0; cause = 0;
    if (m2.v) begin
      if (m2.pc != m_exp) begin fl = 1; cause = m_prevbr ? 1 : 2; end
      else if (m2.av != m_rf[m2.ai]) begin fl = 1; cause = 3; end
      else if (m2.bv != m_rf[m2.bi]) begin fl = 1; cause = 4; end
    end
    cm = m2.v && !fl;
    check("R2/R12 commit valid", int'(cm_valid), int'(cm));
    if (cm) begin
      check("R13 commit pc", int'(cm_pc), m2.pc);
      check("R13 commit write enable", int'(cm_dst_we), int'(m2.we));
      if (m2.we) begin
        check("R13 commit dest index", int'(cm_dst_idx), m2.di);
        check("R13/R11 commit dest value", int'(cm_dst_val), m2.dv);
      end
    end
    check("R8 flush", int'(sq_flush), int'(fl));
    case (cause)
      1: check("R4/R7 cause branch", int'(sq_cause), 1);
      2: check("R3/R7 cause sequential", int'(sq_cause), 2);
      3: check("R5/R7/R11 cause operand A", int'(sq_cause), 3);
      4: check("R6/R7/R11 cause operand B", int'(sq_cause), 4);
      default: check("R7 cause idle", int'(sq_cause), 0);
    endcase
    if (fl) begin
      check("R8 refetch pc", int'(sq_refetch_pc), m_exp);
      seen[cause]++;
    end
    check("R9/R10 degraded", int'(degraded), int'(m_deg));

    // stimulus for the next edge, chosen on the pre-edge state
    s = '{default: 0};
    if (fl) junk(s, g_pc);
    else if (m_deg && !m_busy) begin
      if ($urandom % 4 == 0) junk(s, m_retry + 2 * STEP);
      else gen_normal(s, $urandom % 5 == 0);
    end else if (m_deg) begin
      if ($urandom % 2 == 0) junk(s, m_retry);
    end else if ($urandom % 5 != 0) gen_normal(s, $urandom % 12 == 0);
    acc = s.v && !fl && (!m_deg || (!m_busy && s.pc == m_retry));
    drive(s);
    if (acc) begin
      if (s.we) g_rf[s.di] = s.dv;
      g_pc = succ(s);
    end

    if (fl) begin
      m_deg = 1; m_busy = 0; m_retry = m_exp;
      g_pc = m_exp; g_rf = m_rf;
    end else if (cm) begin
      if (m2.we) m_rf[m2.di] = m2.dv;
      m_exp = succ(m2); m_prevbr = m2.br;
      if (m_deg) begin m_deg = 0; m_busy = 0; end
    end else if (acc && m_deg) m_busy = 1;

    m2 = m1; m2.v = m1.v && !fl;
    m1 = s;  m1.v = acc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    ins_t idle;
    idle = '{default: 0};
    for (int i = 0; i < NUM_REGS; i++) begin m_rf[i] = 0; g_rf[i] = 0; end
    for (int i = 0; i < 5; i++) seen[i] = 0;
    m1 = '{default: 0}; m2 = '{default: 0};
    drive(idle);
    repeat (3) @(negedge clk);
    check("R1 reset commit", int'(cm_valid), 0);
    check("R1 reset flush", int'(sq_flush), 0);
    check("R1 reset degraded", int'(degraded), 0);
    check("R1 reset cause", int'(sq_cause), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      step();
    end
    check("R4 branch fault reached", int'(seen[1] > 0), 1);
    check("R3 sequential fault reached", int'(seen[2] > 0), 1);
    check("R5 operand A fault reached", int'(seen[3] > 0), 1);
    check("R6 operand B fault reached", int'(seen[4] > 0), 1);
    done = 1;
    summary();
    $finish;
  end

endmodule